// File: doc/BRIEF.md
# Eight-bit ALU with status flag register

This block is the arithmetic and logic unit of a small 8-bit RISC core. It takes two 8-bit operands and a 5-bit operation code. In the same cycle it returns an 8-bit result and a write-enable that tells the register file whether to store that result. Six status flags sit in a register inside the block: carry, zero, negative, overflow, sign and half-carry. The operations that use an incoming carry or zero read them from this register.

Each operation has its own fixed set of flags that it may change. On the next rising clock edge, the register loads only the flags in that set. Every other flag keeps its value. The merged next flag value is also presented combinationally, so a branch unit can look ahead one cycle.

The operation set covers:
- addition, with and without carry
- subtraction, with and without borrow
- compare forms that only set flags (a compare against an immediate uses the plain compare code with the constant on `b_i`)
- AND, OR and exclusive-OR
- one's complement and negate
- increment and decrement
- five shifts and rotates
- nibble swap
- a no-operation code

Top module: `alu8_core`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry) give a + b (+ C), write the result, and update all six flags: C is the carry out of bit 7, H is the carry out of bit 3, V is signed overflow, N is bit 7 of the result, and Z is set when the result is zero.
- R2: Codes 2 (subtract) and 3 (subtract with borrow) give a − b (− C) and write it. C is the borrow out of bit 7, H is the borrow into bit 4 from bit 3, and V is signed overflow. All six flags are updated.
- R3: For codes 3 and 5, the new Z is 1 only when the result is zero and Z was already 1. This lets a multi-byte compare chain correctly.
- R4: Codes 4 (compare) and 5 (compare with borrow) set the flags exactly as codes 2 and 3 would, but the write-enable stays low.
- R5: Codes 6 (AND), 7 (OR) and 8 (XOR) write the bitwise result, update Z and N, clear V, and leave C and H unchanged.
- R6: Code 9 writes 0xFF − a, sets C to 1, clears V, updates Z and N, and leaves H unchanged.
- R7: Code 10 writes 0x00 − a. C is 1 unless a is 0, V is 1 only for a = 0x80, and H is 1 when the low nibble of a is non-zero.
- R8: Code 11 writes a + 1 and code 12 writes a − 1. Both update Z and N. V is set only when the value crosses 0x7F/0x80 in the direction of the operation. C and H are unchanged.
- R9: The shift codes are:
  - 13: shift right with 0 into bit 7
  - 14: shift left with 0 into bit 0
  - 15: rotate right through C
  - 16: rotate left through C
  - 17: shift right keeping bit 7

  The bit shifted out goes to C, V becomes N XOR C, Z and N follow the result, and H is unchanged.
- R10: Code 18 writes a with its two nibbles exchanged and changes no flag. Code 19 (and any code above 19) writes nothing and changes no flag.
- R11: The flag vector is laid out as C at bit 0, Z at bit 1, N at bit 2, V at bit 3, S at bit 4 and H at bit 5. S always equals N XOR V.
- R12: Result and write-enable follow the inputs in the same cycle. `flag_nxt_o` shows the value the flag register will load. The register loads it at the next rising edge, only for the flags the operation owns. Reset clears all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand (destination value) |
| b_i | input | 8 | Second operand or immediate |
| result_o | output | 8 | Operation result |
| result_we_o | output | 1 | High when the result is to be written |
| flag_nxt_o | output | 6 | Flag value to be loaded at the next edge |
| flag_q_o | output | 6 | Current flag register |

## Verification
The result, the write-enable and the next flag value are combinational, so they are due in the same cycle the operation is presented. The flag register is due one rising edge later. The bench drives each operation at a falling edge and samples 3 ns later. Each scoreboard entry therefore carries the result, the enable and the next flags of its own operation. It also carries the flags the register should hold while that operation is presented, which are the flags left by the previous entry.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_CP   = 5'd4,
        OP_CPC  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_COM  = 5'd9,
        OP_NEG  = 5'd10,
        OP_INC  = 5'd11,
        OP_DEC  = 5'd12,
        OP_LSR  = 5'd13,
        OP_LSL  = 5'd14,
        OP_ROR  = 5'd15,
        OP_ROL  = 5'd16,
        OP_ASR  = 5'd17,
        OP_SWAP = 5'd18,
        OP_NOP  = 5'd19
    } alu_op_e;

    localparam int FC    = 0;
    localparam int FZ    = 1;
    localparam int FN    = 2;
    localparam int FV    = 3;
    localparam int FS    = 4;
    localparam int FH    = 5;
    localparam int NFLAG = 6;

    localparam logic [NFLAG-1:0] M_ARITH = 6'b111111;
    localparam logic [NFLAG-1:0] M_LOGIC = 6'b011110;
    localparam logic [NFLAG-1:0] M_SHIFT = 6'b011111;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         co,
    output logic         hc,
    output logic         ov
);
    localparam int HB = W / 2;

    logic [W:0]  wide;
    logic [HB:0] low;

    always_comb begin
        if (sub) begin
            wide = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
            low  = {1'b0, x[HB-1:0]} - {1'b0, y[HB-1:0]} - {{HB{1'b0}}, cin};
        end else begin
            wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
            low  = {1'b0, x[HB-1:0]} + {1'b0, y[HB-1:0]} + {{HB{1'b0}}, cin};
        end
        sum = wide[W-1:0];
        co  = wide[W];
        hc  = low[HB];
        if (sub) ov = (x[W-1] != y[W-1]) && (wide[W-1] != x[W-1]);
        else     ov = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         sh_out
);
    localparam int HB = W / 2;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        res    = a;
        sh_out = 1'b0;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM:  res = ~a;
            OP_INC:  res = a + ONE;
            OP_DEC:  res = a - ONE;
            OP_LSR:  begin res = {1'b0, a[W-1:1]};     sh_out = a[0];   end
            OP_LSL:  begin res = {a[W-2:0], 1'b0};     sh_out = a[W-1]; end
            OP_ROR:  begin res = {cin, a[W-1:1]};      sh_out = a[0];   end
            OP_ROL:  begin res = {a[W-2:0], cin};      sh_out = a[W-1]; end
            OP_ASR:  begin res = {a[W-1], a[W-1:1]};   sh_out = a[0];   end
            OP_SWAP: res = {a[HB-1:0], a[W-1:HB]};
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu8_flagfile.sv
module alu8_flagfile #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] upd_mask,
    input  logic [N-1:0] nxt_val,
    output logic [N-1:0] flag_d,
    output logic [N-1:0] flag_q
);
    assign flag_d = (flag_q & ~upd_mask) | (nxt_val & upd_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_hold
        p_hold_unmasked_r12: assert property (@(posedge clk) disable iff (!rst_n)
            !upd_mask[i] |=> $stable(flag_q[i]));
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       op_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    output logic [W-1:0]     result_o,
    output logic             result_we_o,
    output logic [NFLAG-1:0] flag_nxt_o,
    output logic [NFLAG-1:0] flag_q_o
);
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

    alu_op_e          op;
    logic [NFLAG-1:0] flag_q, nxt, mask;
    logic [W-1:0]     as_x, as_y, as_sum, bo_res, res;
    logic             as_cin, as_sub, as_co, as_hc, as_ov, bo_sh;
    logic             c_n, h_n, v_n, z_n, we;

    assign op = alu_op_e'(op_i);

    assign as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP) ||
                    (op == OP_CPC) || (op == OP_NEG);
    assign as_cin = ((op == OP_ADC) || (op == OP_SBC) || (op == OP_CPC)) ? flag_q[FC] : 1'b0;
    assign as_x   = (op == OP_NEG) ? '0  : a_i;
    assign as_y   = (op == OP_NEG) ? a_i : b_i;

    alu8_addsub #(.W(W)) u_addsub (
        .x(as_x), .y(as_y), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .co(as_co), .hc(as_hc), .ov(as_ov)
    );

    alu8_bitops #(.W(W)) u_bitops (
        .op(op), .a(a_i), .b(b_i), .cin(flag_q[FC]),
        .res(bo_res), .sh_out(bo_sh)
    );

    always_comb begin
        res  = a_i;
        we   = 1'b0;
        mask = '0;
        c_n  = flag_q[FC];
        h_n  = flag_q[FH];
        v_n  = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                res = as_sum; we = 1'b1; mask = M_ARITH;
                c_n = as_co;  h_n = as_hc; v_n = as_ov;
            end
            OP_CP, OP_CPC: begin
                res = as_sum; mask = M_ARITH;
                c_n = as_co;  h_n = as_hc; v_n = as_ov;
            end
            OP_AND, OP_OR, OP_XOR: begin
                res = bo_res; we = 1'b1; mask = M_LOGIC;
            end
            OP_COM: begin
                res = bo_res; we = 1'b1; mask = M_SHIFT; c_n = 1'b1;
            end
            OP_INC: begin
                res = bo_res; we = 1'b1; mask = M_LOGIC; v_n = (a_i == MAX_POS);
            end
            OP_DEC: begin
                res = bo_res; we = 1'b1; mask = M_LOGIC; v_n = (a_i == MIN_NEG);
            end
            OP_LSR, OP_LSL, OP_ROR, OP_ROL, OP_ASR: begin
                res = bo_res; we = 1'b1; mask = M_SHIFT;
                c_n = bo_sh;  v_n = bo_res[W-1] ^ bo_sh;
            end
            OP_SWAP: begin
                res = bo_res; we = 1'b1;
            end
            default: begin
                we = 1'b0;
            end
        endcase
    end

    assign z_n = ((op == OP_SBC) || (op == OP_CPC)) ? ((res == '0) && flag_q[FZ])
                                                   : (res == '0);

    always_comb begin
        nxt     = '0;
        nxt[FC] = c_n;
        nxt[FZ] = z_n;
        nxt[FN] = res[W-1];
        nxt[FV] = v_n;
        nxt[FS] = res[W-1] ^ v_n;
        nxt[FH] = h_n;
    end

    alu8_flagfile #(.N(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .upd_mask(mask), .nxt_val(nxt),
        .flag_d(flag_nxt_o), .flag_q(flag_q)
    );

    assign result_o    = res;
    assign result_we_o = we;
    assign flag_q_o    = flag_q;

    p_sign_rule_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q[FS] == (flag_q[FN] ^ flag_q[FV]));

    p_compare_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CP) |=> (flag_q[FZ] == ($past(a_i) == $past(b_i))));

    p_com_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_COM) |=> (flag_q[FC] && !flag_q[FV]));

    p_swap_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_SWAP) || (op_i == OP_NOP)) |=> $stable(flag_q));

    p_inc_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_INC) && (a_i == '1)) |=> flag_q[FZ]);
endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

    localparam int ADD = 0, ADC = 1, SUB = 2, SBC = 3, CP = 4, CPC = 5;
    localparam int AND_ = 6, OR_ = 7, XOR_ = 8, COM = 9, NEG = 10, INC = 11, DEC = 12;
    localparam int LSR = 13, LSL = 14, ROR = 15, ROL = 16, ASR = 17, SWAP = 18, NOP = 19;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_s = 5'd19;
    logic [7:0] a_s = 8'h00, b_s = 8'h00;
    logic [7:0] result_o;
    logic       result_we_o;
    logic [5:0] flag_nxt_o, flag_q_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_s), .a_i(a_s), .b_i(b_s),
        .result_o(result_o), .result_we_o(result_we_o),
        .flag_nxt_o(flag_nxt_o), .flag_q_o(flag_q_o)
    );

    typedef struct {
        logic [7:0] res;
        logic       we;
        logic [5:0] fl_now;
        logic [5:0] fl_nxt;
        string      tag;
        string      prev_tag;
    } exp_t;

    exp_t       sb_q[$];
    logic [5:0] model_f = 6'h00;
    string      last_tag = "R12";

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic model(input int op, input int ua, input int ub, input logic [5:0] f,
                         output logic [7:0] r, output logic w, output logic [5:0] nf);
        int ci, s, sv, sa, sb, co;
        logic n, v;
        sa = (ua > 127) ? ua - 256 : ua;
        sb = (ub > 127) ? ub - 256 : ub;
        nf = f;
        w = 1'b1;
        r = 8'(ua);
        if (op <= 1) begin
            ci = (op == 1) ? int'(f[0]) : 0;
            s = ua + ub + ci;
            sv = sa + sb + ci;
            r = 8'(s);
            nf[0] = s > 255;
            nf[5] = (ua % 16 + ub % 16 + ci) > 15;
            nf[3] = (sv > 127) || (sv < -128);
            nf[1] = (r == 8'h00);
            nf[2] = r[7];
        end else if (op <= 5) begin
            ci = (op == 3 || op == 5) ? int'(f[0]) : 0;
            s = ua - ub - ci;
            sv = sa - sb - ci;
            r = 8'(s);
            w = (op <= 3);
            nf[0] = s < 0;
            nf[5] = (ua % 16 - ub % 16 - ci) < 0;
            nf[3] = (sv > 127) || (sv < -128);
            nf[1] = (r == 8'h00) && ((op == 3 || op == 5) ? f[1] : 1'b1);
            nf[2] = r[7];
        end else if (op <= 12) begin
            case (op)
                6: r = 8'(ua & ub);
                7: r = 8'(ua | ub);
                8: r = 8'(ua ^ ub);
                9: r = 8'(255 - ua);
                10: r = 8'(256 - ua);
                11: r = 8'(ua + 1);
                default: r = 8'(ua + 255);
            endcase
            nf[1] = (r == 8'h00);
            nf[2] = r[7];
            nf[3] = (op == 11) ? (ua == 127) : (op == 12) ? (ua == 128) : (op == 10) ? (ua == 128) : 1'b0;
            if (op == 9) nf[0] = 1'b1;
            if (op == 10) begin nf[0] = (ua != 0); nf[5] = (ua % 16) != 0; end
        end else if (op <= 17) begin
            case (op)
                13: begin s = ua / 2;                          co = ua % 2; end
                14: begin s = (ua * 2) % 256;                  co = ua / 128; end
                15: begin s = ua / 2 + 128 * int'(f[0]);       co = ua % 2; end
                16: begin s = (ua * 2) % 256 + int'(f[0]);     co = ua / 128; end
                default: begin s = ua / 2 + (ua / 128) * 128;  co = ua % 2; end
            endcase
            r = 8'(s);
            n = r[7];
            nf[0] = co[0];
            nf[1] = (r == 8'h00);
            nf[2] = n;
            nf[3] = n ^ co[0];
        end else if (op == 18) begin
            r = 8'((ua % 16) * 16 + ua / 16);
        end else begin
            w = 1'b0;
        end
        if (op <= 17) begin
            v = nf[3];
            nf[4] = nf[2] ^ v;
        end
    endtask

    task automatic step(input int op, input int a, input int b, input string tag);
        exp_t e;
        logic [7:0] r;
        logic w;
        logic [5:0] nf;
        model(op, a, b, model_f, r, w, nf);
        @(negedge clk);
        op_s = 5'(op);
        a_s = 8'(a);
        b_s = 8'(b);
        e.res = r;
        e.we = w;
        e.fl_now = model_f;
        e.fl_nxt = nf;
        e.tag = tag;
        e.prev_tag = last_tag;
        sb_q.push_back(e);
        model_f = nf;
        last_tag = tag;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.prev_tag, "flags", int'(flag_q_o), int'(e.fl_now));
                check(e.tag, "we", int'(result_we_o), int'(e.we));
                if (e.we) check(e.tag, "result", int'(result_o), int'(e.res));
                check(e.tag, "flag_nxt", int'(flag_nxt_o), int'(e.fl_nxt));
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        #3;
        check("R12", "reset flags", int'(flag_q_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 add and add with carry
        step(ADD, 8'h3A, 8'h28, "R1");
        step(ADD, 8'h7F, 8'h01, "R1");
        step(ADD, 8'hFF, 8'h01, "R1");
        step(ADC, 8'h10, 8'h20, "R1");
        step(ADC, 8'h80, 8'h80, "R1");
        // R2 subtract and subtract with borrow
        step(SUB, 8'h10, 8'h01, "R2");
        step(SUB, 8'h80, 8'h01, "R2");
        step(SBC, 8'h05, 8'h05, "R2");
        // R3 zero chaining
        step(SUB, 8'h12, 8'h12, "R3");
        step(SBC, 8'h00, 8'h00, "R3");
        step(SUB, 8'h10, 8'h20, "R3");
        step(SBC, 8'h01, 8'h00, "R3");
        // R4 compares leave no result
        step(CP, 8'h44, 8'h44, "R4");
        step(CP, 8'h20, 8'h30, "R4");
        step(CPC, 8'h31, 8'h30, "R4");
        step(CPC, 8'h00, 8'h00, "R4");
        // R5 logic
        step(ADD, 8'hF8, 8'h18, "R5");
        step(AND_, 8'hF0, 8'h0F, "R5");
        step(OR_, 8'h80, 8'h01, "R5");
        step(XOR_, 8'hAA, 8'hAA, "R5");
        // R6 complement
        step(COM, 8'hFF, 8'h00, "R6");
        step(COM, 8'h0F, 8'h00, "R6");
        // R7 negate
        step(NEG, 8'h00, 8'h00, "R7");
        step(NEG, 8'h80, 8'h00, "R7");
        step(NEG, 8'h01, 8'h00, "R7");
        step(NEG, 8'h10, 8'h00, "R7");
        // R8 increment and decrement
        step(INC, 8'h7F, 8'h00, "R8");
        step(INC, 8'hFF, 8'h00, "R8");
        step(DEC, 8'h80, 8'h00, "R8");
        step(DEC, 8'h00, 8'h00, "R8");
        // R9 shifts and rotates
        step(LSR, 8'h81, 8'h00, "R9");
        step(ROR, 8'h02, 8'h00, "R9");
        step(LSL, 8'h80, 8'h00, "R9");
        step(ROL, 8'h40, 8'h00, "R9");
        step(ASR, 8'h85, 8'h00, "R9");
        step(ASR, 8'h01, 8'h00, "R9");
        // R10 swap and no-op
        step(SWAP, 8'h3C, 8'h00, "R10");
        step(NOP, 8'h00, 8'h00, "R10");
        // R11 mixed traffic, sign rule checked through every flag vector
        lfsr = 32'hACE1_2357;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(int'(lfsr[15:0]) % 20, int'(lfsr[23:16]), int'(lfsr[31:24]), "R11");
        end
        step(NOP, 0, 0, "R12");
        step(NOP, 0, 0, "R12");
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule